// File: doc/BRIEF.md
# Two-Strike Watchdog Timer

This peripheral watches over system software from a slow oscillator clock while it is programmed from a faster bus clock. Software loads a 12-bit period and turns counting on. After that it must keep writing a keep-alive kick. The counter advances once every PRESCALE oscillator cycles, and one overflow interval spans PRESCALE × (period + 1) oscillator cycles. The first overflow without a kick raises an interrupt flag, which gives software a last chance to act. A second overflow in a row drives the reset output. Software can also pull the reset output on purpose by injecting a parity error.

Writes to every register except the kick register pass through a toggle handshake into the oscillator domain. They take effect a few cycles after the bus write. The kick clears the interrupt flag on the bus side at once, and it sends a separate pulse that clears the lapsed count in the oscillator domain. Reads come back one bus cycle after the read strobe. The reset output is sticky: only the block's own reset input removes it.

Top module: `wdg_dualovf`

## Requirements
- R1: After the reset input, the control (0x00), period (0x04), kick (0x0C) and parity-control (0x10) registers read 0, and irq and wdt_reset are low.
- R2: The period register keeps only write-data bits 31:20 as the period. A read of 0x04 returns the period in bits 31:20 and zeros in every other bit.
- R3: While bit 0 of the control register is 1, one overflow interval lasts PRESCALE × (period + 1) oscillator cycles. The first overflow sets irq, and a read of 0x0C then returns bit 0 = 1.
- R4: wdt_reset rises only at the second consecutive overflow with no kick in between, or on a forced parity error.
- R5: A write with bit 0 = 1 to 0x0C clears irq and also clears the lapsed count and the overflow history. Kicks spaced closer than one interval keep wdt_reset low indefinitely.
- R6: Any write to 0x08 restarts the running count from zero, and this postpones the next overflow.
- R7: While control bit 0 is 0 nothing counts, so neither irq nor wdt_reset is raised.
- R8: A write with bit 0 = 1 to 0x14 asserts wdt_reset when bit 0 of the parity-control register (0x10) is 0. The same write has no effect when that bit is 1.
- R9: A period write while counting is enabled is ignored. The readback and the interval both keep the old value.
- R10: Once asserted, wdt_reset stays high until the reset input is applied.
- R11: A kick clears irq on the next bus clock edge. Every other register write reaches the oscillator domain only after synchronisation, so its effect lags the write by several cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register interface clock |
| osc_clk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous active-high reset, bus domain, synchronised internally into the oscillator domain |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid one bus cycle after rd_en |
| irq | output | 1 | First-overflow interrupt flag (bus domain) |
| wdt_reset | output | 1 | Sticky reset request (oscillator domain) |

## Verification
The assertions check on every cycle that the reset request is sticky, that it rises only out of the armed second stage or a forced parity error, that a kick disarms the stage, that the period is frozen while counting, that an idle counter never arms, and that irq rises only after an overflow event crosses into the bus domain. The bench scenarios are the only way to show the interval length itself, the masking of the period field and the readback values. They also show that steady kicking holds reset off, that a counter restart postpones the overflow, that the parity-control bit gates the forced reset, and how long each crossed write takes to act.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // byte offsets; decoding depends on these
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_PERIOD = 'h04;
  localparam int OFS_INIT   = 'h08;
  localparam int OFS_KICK   = 'h0C;
  localparam int OFS_PECTL  = 'h10;
  localparam int OFS_PEFRC  = 'h14;

  // operation carried across the clock-domain handshake
  typedef enum logic [2:0] {
    OP_CTRL   = 3'd0,
    OP_PERIOD = 3'd1,
    OP_INIT   = 3'd2,
    OP_PECTL  = 3'd3,
    OP_PEFRC  = 3'd4
  } xop_t;
endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int PER_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              req_tgl,
  output xop_t              xop,
  output logic [PER_W-1:0]  xval,
  output logic              kick_tgl,
  input  logic              ack_sync,
  input  logic              ovf_sync
);
  localparam int PER_LSB = DATA_W - PER_W;

  logic             busy;
  logic             ctl_en;
  logic             pe_mask;
  logic [PER_W-1:0] period_sh;
  logic             ovf_last;
  logic             unused_wd;

  assign unused_wd = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      ctl_en    <= 1'b0;
      pe_mask   <= 1'b0;
      period_sh <= '0;
      ovf_last  <= 1'b0;
      irq       <= 1'b0;
      req_tgl   <= 1'b0;
      xop       <= OP_CTRL;
      xval      <= '0;
      kick_tgl  <= 1'b0;
      rdata     <= '0;
    end else begin
      ovf_last <= ovf_sync;
      if (busy && (ack_sync == req_tgl)) busy <= 1'b0;
      if (ovf_sync != ovf_last) irq <= 1'b1;

      if (wr_en) begin
        case (int'(addr))
          OFS_KICK: begin
            if (wdata[0]) begin
              irq      <= 1'b0;
              kick_tgl <= ~kick_tgl;
            end
          end
          OFS_CTRL: begin
            if (!busy) begin
              ctl_en  <= wdata[0];
              xop     <= OP_CTRL;
              xval    <= PER_W'(wdata[0]);
              req_tgl <= ~req_tgl;
              busy    <= 1'b1;
            end
          end
          OFS_PERIOD: begin
            if (!busy) begin
              if (!ctl_en) period_sh <= wdata[PER_LSB +: PER_W];
              xop     <= OP_PERIOD;
              xval    <= wdata[PER_LSB +: PER_W];
              req_tgl <= ~req_tgl;
              busy    <= 1'b1;
            end
          end
          OFS_INIT: begin
            if (!busy) begin
              xop     <= OP_INIT;
              xval    <= '0;
              req_tgl <= ~req_tgl;
              busy    <= 1'b1;
            end
          end
          OFS_PECTL: begin
            if (!busy) begin
              pe_mask <= wdata[0];
              xop     <= OP_PECTL;
              xval    <= PER_W'(wdata[0]);
              req_tgl <= ~req_tgl;
              busy    <= 1'b1;
            end
          end
          OFS_PEFRC: begin
            if (!busy && wdata[0]) begin
              xop     <= OP_PEFRC;
              xval    <= PER_W'(1);
              req_tgl <= ~req_tgl;
              busy    <= 1'b1;
            end
          end
          default: ;
        endcase
      end

      if (rd_en) begin
        case (int'(addr))
          OFS_CTRL:   rdata <= DATA_W'(ctl_en);
          OFS_PERIOD: rdata <= {period_sh, {PER_LSB{1'b0}}};
          OFS_KICK:   rdata <= DATA_W'(irq);
          OFS_PECTL:  rdata <= DATA_W'(pe_mask);
          default:    rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
#(
  parameter int PER_W    = 12,
  parameter int PRESCALE = 1048576
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_sync,
  input  logic             kick_sync,
  input  xop_t             xop,
  input  logic [PER_W-1:0] xval,
  output logic             ack_tgl,
  output logic             ovf_tgl,
  output logic             wdt_reset,
  output logic             run,
  output logic             stage,
  output logic             kick_evt,
  output logic             fire_evt,
  output logic [PER_W-1:0] period
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic             req_last;
  logic             kick_last;
  logic             pe_mask;
  logic [PRE_W-1:0] pre_cnt;
  logic [PER_W-1:0] per_cnt;
  logic             req_evt;
  logic             pre_wrap;
  logic             per_hit;
  logic             ovf;

  assign req_evt  = req_sync ^ req_last;
  assign kick_evt = kick_sync ^ kick_last;
  assign pre_wrap = (pre_cnt == PRE_LAST);
  assign per_hit  = (per_cnt == period);
  assign ovf      = run && pre_wrap && per_hit;
  assign fire_evt = req_evt && (xop == OP_PEFRC) && !pe_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_last  <= 1'b0;
      kick_last <= 1'b0;
      ack_tgl   <= 1'b0;
      ovf_tgl   <= 1'b0;
      wdt_reset <= 1'b0;
      run       <= 1'b0;
      stage     <= 1'b0;
      pe_mask   <= 1'b0;
      period    <= '0;
      pre_cnt   <= '0;
      per_cnt   <= '0;
    end else begin
      req_last  <= req_sync;
      kick_last <= kick_sync;
      ack_tgl   <= req_sync;

      if (run) begin
        if (pre_wrap) begin
          pre_cnt <= '0;
          per_cnt <= per_hit ? '0 : per_cnt + PER_W'(1);
        end else begin
          pre_cnt <= pre_cnt + PRE_W'(1);
        end
      end

      if (ovf) begin
        if (stage) wdt_reset <= 1'b1;
        else begin
          stage   <= 1'b1;
          ovf_tgl <= ~ovf_tgl;
        end
      end

      if (req_evt) begin
        case (xop)
          OP_CTRL:   run <= xval[0];
          OP_PERIOD: if (!run) period <= xval;
          OP_INIT: begin
            pre_cnt <= '0;
            per_cnt <= '0;
          end
          OP_PECTL:  pe_mask <= xval[0];
          OP_PEFRC:  if (!pe_mask) wdt_reset <= 1'b1;
          default: ;
        endcase
      end

      if (kick_evt) begin
        pre_cnt <= '0;
        per_cnt <= '0;
        stage   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdg_dualovf.sv
module wdg_dualovf
  import wdg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int PER_W       = 12,
  parameter int PRESCALE    = 1048576,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              osc_clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              wdt_reset
);
  logic             osc_rst;
  logic             req_tgl, req_sync;
  logic             kick_tgl, kick_sync;
  logic             ack_tgl, ack_sync;
  logic             ovf_tgl, ovf_sync;
  xop_t             xop;
  logic [PER_W-1:0] xval;
  logic             core_run, core_stage, core_kick, core_fire;
  logic [PER_W-1:0] core_period;

  wdg_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(osc_clk), .rst(1'b0), .d(rst), .q(osc_rst));
  wdg_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(osc_clk), .rst(osc_rst), .d(req_tgl), .q(req_sync));
  wdg_sync #(.STAGES(SYNC_STAGES)) u_kick_sync (
    .clk(osc_clk), .rst(osc_rst), .d(kick_tgl), .q(kick_sync));
  wdg_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(bus_clk), .rst(rst), .d(ack_tgl), .q(ack_sync));
  wdg_sync #(.STAGES(SYNC_STAGES)) u_ovf_sync (
    .clk(bus_clk), .rst(rst), .d(ovf_tgl), .q(ovf_sync));

  wdg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PER_W(PER_W)) u_regs (
    .clk(bus_clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .req_tgl(req_tgl), .xop(xop),
    .xval(xval), .kick_tgl(kick_tgl), .ack_sync(ack_sync), .ovf_sync(ovf_sync));

  wdg_core #(.PER_W(PER_W), .PRESCALE(PRESCALE)) u_core (
    .clk(osc_clk), .rst(osc_rst), .req_sync(req_sync), .kick_sync(kick_sync),
    .xop(xop), .xval(xval), .ack_tgl(ack_tgl), .ovf_tgl(ovf_tgl),
    .wdt_reset(wdt_reset), .run(core_run), .stage(core_stage),
    .kick_evt(core_kick), .fire_evt(core_fire), .period(core_period));
endmodule

// File: rtl/wdg_dualovf_chk.sv
module wdg_dualovf_chk #(
  parameter int PER_W = 12
) (
  input logic             bus_clk,
  input logic             osc_clk,
  input logic             rst,
  input logic             osc_rst,
  input logic             irq,
  input logic             ovf_sync,
  input logic             wdt_reset,
  input logic             run,
  input logic             stage,
  input logic             kick_evt,
  input logic             fire_evt,
  input logic [PER_W-1:0] period
);
  // R1: flag is clear on the first cycle out of reset
  a_r1_irq_clear: assert property (@(posedge bus_clk) disable iff (rst)
    $fell(rst) |-> !irq);

  // R3: irq rises only after an overflow toggle reached the bus domain
  a_r3_irq_from_overflow: assert property (@(posedge bus_clk) disable iff (rst)
    $rose(irq) |-> ($past(ovf_sync) != $past(ovf_sync, 2)));

  // R4, R8: reset request comes from the armed stage or a forced parity error
  a_r4_second_overflow: assert property (@(posedge osc_clk) disable iff (osc_rst)
    $rose(wdt_reset) |-> ($past(stage) || $past(fire_evt)));

  // R10: sticky until reset
  a_r10_reset_sticky: assert property (@(posedge osc_clk) disable iff (osc_rst)
    wdt_reset |=> wdt_reset);

  // R5: a kick disarms the first-overflow stage
  a_r5_kick_disarms: assert property (@(posedge osc_clk) disable iff (osc_rst)
    kick_evt |=> !stage);

  // R9: period frozen while counting
  a_r9_period_frozen: assert property (@(posedge osc_clk) disable iff (osc_rst)
    (run && $past(run)) |-> $stable(period));

  // R7: an idle counter never arms
  a_r7_idle_no_arm: assert property (@(posedge osc_clk) disable iff (osc_rst)
    !run |=> !$rose(stage));
endmodule

bind wdg_dualovf wdg_dualovf_chk #(.PER_W(PER_W)) u_chk (
  .bus_clk(bus_clk), .osc_clk(osc_clk), .rst(rst), .osc_rst(osc_rst),
  .irq(irq), .ovf_sync(ovf_sync), .wdt_reset(wdt_reset), .run(core_run),
  .stage(core_stage), .kick_evt(core_kick), .fire_evt(core_fire),
  .period(core_period));

// File: tb/wdg_dualovf_test.sv
module wdg_dualovf_test;
  localparam int DW = 32;
  localparam int AW = 5;

  logic          bus_clk = 1'b0;
  logic          osc_clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  logic          wdt_reset;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 bus_clk = ~bus_clk;   // 250 MHz
  always #5 osc_clk = ~osc_clk;   // counting clock

  wdg_dualovf #(.PRESCALE(4)) uut (
    .bus_clk(bus_clk), .osc_clk(osc_clk), .rst(rst), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
    .wdt_reset(wdt_reset));

  // scoreboard queues of expected read data
  string       tag_q[$];
  logic [31:0] val_q[$];
  logic        rd_seen = 1'b0;

  always @(posedge bus_clk) rd_seen <= rd_en;

  always @(negedge bus_clk) begin
    if (rd_seen) begin
      n_chk++;
      if (val_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read act=%h exp=none", rdata);
      end else begin
        string       t;
        logic [31:0] e;
        t = tag_q.pop_front();
        e = val_q.pop_front();
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s read act=%h exp=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic rd_push(input int a, input logic [31:0] e, input string t);
    @(negedge bus_clk);
    addr = AW'(a);
    rd_en = 1'b1;
    tag_q.push_back(t);
    val_q.push_back(e);
    @(negedge bus_clk);
    rd_en = 1'b0;
    @(negedge bus_clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge bus_clk);
    addr = AW'(a);
    wdata = d;
    wr_en = 1'b1;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (30) @(negedge bus_clk);
  endtask

  task automatic wait_osc(input int n);
    repeat (n) @(posedge osc_clk);
    #2;
  endtask

  task automatic pin_chk(input string t, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0b exp=%0b", t, act, exp);
    end
  endtask

  task automatic do_rst();
    @(negedge bus_clk);
    rst = 1'b1;
    repeat (8) @(posedge osc_clk);
    @(negedge bus_clk);
    rst = 1'b0;
    repeat (4) @(posedge osc_clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    do_rst();
    // R1 reset state
    pin_chk("R1 irq", irq, 1'b0);
    pin_chk("R1 wdt_reset", wdt_reset, 1'b0);
    rd_push('h00, 32'h0, "R1 ctrl");
    rd_push('h04, 32'h0, "R1 period");
    rd_push('h0C, 32'h0, "R1 kick");
    rd_push('h10, 32'h0, "R1 pectl");

    // R2 field masking
    wr('h04, 32'hFFFF_FFFF); settle();
    rd_push('h04, 32'hFFF0_0000, "R2 all ones");
    wr('h04, 32'h0030_1234); settle();
    rd_push('h04, 32'h0030_0000, "R2 period 3");

    // R3, R4, R10: interval 4*(3+1)=16 osc cycles
    wr('h00, 32'h1);
    wait_osc(15);
    pin_chk("R3 no irq before first overflow", irq, 1'b0);
    wait_osc(10);
    pin_chk("R3 irq after first overflow", irq, 1'b1);
    rd_push('h0C, 32'h1, "R3 flag readback");
    wait_osc(4);
    pin_chk("R4 no reset after one overflow", wdt_reset, 1'b0);
    wait_osc(15);
    pin_chk("R4 reset after second overflow", wdt_reset, 1'b1);
    wait_osc(40);
    pin_chk("R10 reset stays high", wdt_reset, 1'b1);
    do_rst();
    pin_chk("R10 reset cleared by rst", wdt_reset, 1'b0);

    // R5 steady kicking, R11 immediate irq clear
    wr('h04, 32'h0030_0000); settle();
    wr('h00, 32'h1);
    for (int i = 0; i < 10; i++) begin
      wait_osc(10);
      wr('h0C, 32'h1);
    end
    pin_chk("R5 kicked no reset", wdt_reset, 1'b0);
    pin_chk("R5 kicked no irq", irq, 1'b0);
    wait_osc(25);
    pin_chk("R5 irq set when kicks stop", irq, 1'b1);
    wr('h0C, 32'h1);
    pin_chk("R11 kick clears irq at once", irq, 1'b0);
    wait_osc(20);
    pin_chk("R5 kick cleared lapsed count", wdt_reset, 1'b0);
    do_rst();

    // R6 counter restart
    wr('h04, 32'h0030_0000); settle();
    wr('h00, 32'h1);
    wait_osc(12);
    wr('h08, 32'h0);
    wait_osc(12);
    pin_chk("R6 restart postpones overflow", irq, 1'b0);
    wait_osc(16);
    pin_chk("R6 overflow after restart", irq, 1'b1);
    do_rst();

    // R9 period write ignored while running
    wr('h04, 32'h0030_0000); settle();
    wr('h00, 32'h1);
    wait_osc(5);
    wr('h04, 32'h0FF0_0000);
    rd_push('h04, 32'h0030_0000, "R9 readback unchanged");
    wait_osc(18);
    pin_chk("R9 interval unchanged", irq, 1'b1);
    do_rst();

    // R7 disabled counter
    wr('h04, 32'h0030_0000); settle();
    wait_osc(100);
    pin_chk("R7 idle no irq", irq, 1'b0);
    pin_chk("R7 idle no reset", wdt_reset, 1'b0);
    rd_push('h0C, 32'h0, "R7 flag clear");

    // R8 forced parity error, R11 crossing delay
    wr('h10, 32'h1); settle();
    rd_push('h10, 32'h1, "R8 pectl readback");
    wr('h14, 32'h1); settle();
    pin_chk("R8 masked force ignored", wdt_reset, 1'b0);
    wr('h10, 32'h0); settle();
    wr('h14, 32'h1);
    pin_chk("R11 force not yet applied", wdt_reset, 1'b0);
    settle();
    pin_chk("R8 force asserts reset", wdt_reset, 1'b1);
    do_rst();
    pin_chk("R1 reset output low after rst", wdt_reset, 1'b0);

    repeat (4) @(negedge bus_clk);
    finish_run();
  end
endmodule